// File: doc/BRIEF.md
# Stack and Subroutine Sequencer

This block carries out the stack-based control transfers of a 16-bit processor. The decode stage hands it a single command: push, pop, subroutine call, return from subroutine or return from interrupt. The block then runs the memory accesses the command needs on a plain word memory port, and it owns the stack pointer for the whole of that sequence. When the sequence ends, it raises a one-cycle completion strobe. In that same cycle it presents the value that was popped or the new program counter, together with a write strobe for the counter.

The stack grows downward and every item takes two bytes, byte-sized operations included. Writing an item first steps the stack pointer down and then stores at the new address. Reading an item loads from the current address and then steps the pointer up. A return from interrupt always runs two reads. The first restores the status register and the second restores the program counter. Each memory request holds its address, data and direction until the memory acknowledges it. The stack pointer changes only in the cycle in which an access completes.

Top module: `stkseq_top`

## Requirements
- R1: After reset the stack pointer equals the SP_TOP parameter with bit 0 forced to zero, cmd_ready is high, and done and mem_req are low. Bit 0 of the stack pointer stays zero at all times.
- R2: A word push (cmd_op 0, cmd_byte 0) writes cmd_src at the address SP-2 and then leaves SP at SP-2.
- R3: A byte push (cmd_op 0, cmd_byte 1) writes cmd_src[7:0] with its upper byte zero and moves SP by 2.
- R4: A word pop (cmd_op 1, cmd_byte 0) reads the word at SP and presents it on pop_data while done is high. Afterwards SP is SP+2.
- R5: A byte pop (cmd_op 1, cmd_byte 1) presents only the low byte of the word read, with the upper byte zero, and moves SP by 2.
- R6: A call (cmd_op 2) writes pc_in+2 at SP-2 and leaves SP at SP-2. In the done cycle it raises pc_wr with pc_out equal to cmd_src.
- R7: A return from subroutine (cmd_op 3) reads the word at SP and raises pc_wr with that word on pc_out in the done cycle. Afterwards SP is SP+2.
- R8: A return from interrupt (cmd_op 4) first reads SP and then reads SP+2. It pulses sr_wr for one cycle with the first word on sr_out before done. In the done cycle it raises pc_wr with the second word on pc_out. Afterwards SP is SP+4.
- R9: While mem_req is high and mem_ack is low, mem_addr, mem_wdata and mem_we hold their values. The stack pointer changes only on a cycle with mem_req and mem_ack both high.
- R10: done is high for exactly one cycle per command. A cmd_valid that arrives while cmd_ready is low starts no access and is not queued.
- R11: The codes 5 to 7 on cmd_op are ignored. They start no memory access, raise no done and leave the stack pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request, taken only while cmd_ready is high |
| cmd_op | input | 3 | 0 push, 1 pop, 2 call, 3 return, 4 return from interrupt |
| cmd_byte | input | 1 | Byte-sized push or pop |
| cmd_src | input | 16 | Value to push, or call target |
| pc_in | input | 16 | Current program counter, used by call |
| cmd_ready | output | 1 | Sequencer idle |
| done | output | 1 | One-cycle completion strobe |
| pop_data | output | 16 | Popped value, valid with done |
| pc_wr | output | 1 | Program counter load strobe, high with done |
| pc_out | output | 16 | New program counter value |
| sr_wr | output | 1 | Status register load strobe |
| sr_out | output | 16 | Restored status register value |
| sp_out | output | 16 | Current stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address of the access |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Access completes in this cycle |
| mem_rdata | input | 16 | Read data, sampled when mem_ack is high |

## Verification
A stack pointer that is off by one slot shows up on mem_addr at the very next access. It also shows on sp_out in the done cycle, so the error is visible no more than a few cycles after the command. Data written to the wrong place stays hidden until a later pop or return reads that slot, so the random mix of pushes and pops with varying acknowledge latency compares every popped value with a bench-side stack image. If the state machine takes the wrong path, a return from interrupt loads the two words in the wrong order, or done or an access appears where none is due. Each command checks these in its own done cycle and in the cycle after.

// File: rtl/stkseq_pkg.sv
package stkseq_pkg;
  localparam int unsigned WORD_W     = 16;
  localparam int unsigned SLOT_BYTES = WORD_W / 8;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_POP  = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_RETI = 3'd4
  } stk_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ_SR,
    ST_READ_W,
    ST_DONE
  } stk_state_e;

  // address of the slot just below the current top
  function automatic word_t slot_below(word_t sp);
    return sp - word_t'(SLOT_BYTES);
  endfunction

  // stack pointer after one item is removed
  function automatic word_t slot_above(word_t sp);
    return sp + word_t'(SLOT_BYTES);
  endfunction

  // byte-sized items keep only the low byte, zero-extended
  function automatic word_t fit_size(word_t v, logic is_byte);
    return is_byte ? {{(WORD_W-8){1'b0}}, v[7:0]} : v;
  endfunction

  function automatic word_t link_addr(word_t pc);
    return pc + word_t'(SLOT_BYTES);
  endfunction

  function automatic logic op_known(logic [2:0] op);
    return op <= 3'd4;
  endfunction
endpackage

// File: rtl/stkseq_sp.sv
module stkseq_sp
  import stkseq_pkg::*;
#(
  parameter word_t TOP = 16'h0400
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step_down,
  input  logic  step_up,
  output word_t sp
);
  localparam word_t RESET_SP = TOP & ~word_t'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sp <= RESET_SP;
    else if (step_down) sp <= slot_below(sp);
    else if (step_up)   sp <= slot_above(sp);
  end

  // R1
  sp_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp[0] == 1'b0);

  // R9
  sp_step_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_down && step_up));
endmodule

// File: rtl/stkseq_mport.sv
module stkseq_mport
  import stkseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_act,
  input  logic  rd_act,
  input  word_t sp,
  input  logic  load,
  input  word_t load_val,
  input  logic  ack,
  output logic  req,
  output logic  we,
  output word_t addr,
  output word_t wdata
);
  word_t wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    wdata_q <= '0;
    else if (load) wdata_q <= load_val;
  end

  assign req   = wr_act | rd_act;
  assign we    = wr_act;
  assign addr  = wr_act ? slot_below(sp) : sp;
  assign wdata = wdata_q;

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> (req && $stable(addr) && $stable(wdata) && $stable(we)));
endmodule

// File: rtl/stkseq_top.sv
module stkseq_top
  import stkseq_pkg::*;
#(
  parameter word_t SP_TOP = 16'h0400
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_op,
  input  logic        cmd_byte,
  input  logic [15:0] cmd_src,
  input  logic [15:0] pc_in,
  output logic        cmd_ready,
  output logic        done,
  output logic [15:0] pop_data,
  output logic        pc_wr,
  output logic [15:0] pc_out,
  output logic        sr_wr,
  output logic [15:0] sr_out,
  output logic [15:0] sp_out,
  output logic        mem_req,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [15:0] mem_rdata
);
  stk_state_e state;
  stk_op_e    op_q;
  logic       byte_q;
  word_t      pc_q, pop_q, sr_q;
  logic       sr_wr_q;

  // named internal events
  logic  accept, xfer, sp_dec, sp_inc, wr_act, rd_act;
  word_t wr_val;

  assign accept = (state == ST_IDLE) && cmd_valid && op_known(cmd_op);
  assign xfer   = mem_req && mem_ack;
  assign wr_act = (state == ST_WRITE);
  assign rd_act = (state == ST_READ_SR) || (state == ST_READ_W);
  assign sp_dec = wr_act && xfer;
  assign sp_inc = rd_act && xfer;
  assign wr_val = (stk_op_e'(cmd_op) == OP_CALL) ? link_addr(pc_in)
                                                 : fit_size(cmd_src, cmd_byte);

  stkseq_sp #(.TOP(SP_TOP)) u_sp (
    .clk(clk), .rst_n(rst_n), .step_down(sp_dec), .step_up(sp_inc), .sp(sp_out)
  );

  stkseq_mport u_mport (
    .clk(clk), .rst_n(rst_n), .wr_act(wr_act), .rd_act(rd_act), .sp(sp_out),
    .load(accept), .load_val(wr_val), .ack(mem_ack),
    .req(mem_req), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      op_q    <= OP_PUSH;
      byte_q  <= 1'b0;
      pc_q    <= '0;
      pop_q   <= '0;
      sr_q    <= '0;
      sr_wr_q <= 1'b0;
    end else begin
      sr_wr_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          op_q   <= stk_op_e'(cmd_op);
          byte_q <= cmd_byte;
          if (stk_op_e'(cmd_op) == OP_CALL) pc_q <= cmd_src;
          unique case (stk_op_e'(cmd_op))
            OP_PUSH, OP_CALL: state <= ST_WRITE;
            OP_RETI:          state <= ST_READ_SR;
            default:          state <= ST_READ_W;
          endcase
        end
        ST_WRITE: if (xfer) state <= ST_DONE;
        ST_READ_SR: if (xfer) begin
          sr_q    <= mem_rdata;
          sr_wr_q <= 1'b1;
          state   <= ST_READ_W;
        end
        ST_READ_W: if (xfer) begin
          if (op_q == OP_POP) pop_q <= fit_size(mem_rdata, byte_q);
          else                pc_q  <= mem_rdata;
          state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == ST_IDLE);
  assign done      = (state == ST_DONE);
  assign pc_wr     = done && (op_q != OP_PUSH) && (op_q != OP_POP);
  assign pc_out    = pc_q;
  assign pop_data  = pop_q;
  assign sr_wr     = sr_wr_q;
  assign sr_out    = sr_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  sp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(sp_out));

  // R2
  push_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && mem_we) |=> (sp_out == $past(mem_addr)));

  // R4
  pop_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !mem_we) |=> (sp_out == $past(mem_addr) + word_t'(SLOT_BYTES)));

  // R8
  sr_before_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr |-> (!pc_wr && mem_req && !mem_we));

  // R11
  unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (cmd_op > 3'd4)) |=> (cmd_ready && !mem_req));
endmodule

// File: tb/test_stkseq_top.sv
module test_stkseq_top;
  import stkseq_pkg::*;

  localparam logic [15:0] TOP_CFG = 16'h0401;
  localparam logic [15:0] TOP_EXP = 16'h0400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic        cmd_byte = 1'b0;
  logic [15:0] cmd_src = '0;
  logic [15:0] pc_in = '0;
  logic        cmd_ready, done, pc_wr, sr_wr, mem_req, mem_we;
  logic [15:0] pop_data, pc_out, sr_out, sp_out, mem_addr, mem_wdata, mem_rdata;
  logic        mem_ack = 1'b0;

  always #4 clk = ~clk;

  stkseq_top #(.SP_TOP(TOP_CFG)) i_stkseq_top (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .cmd_src(cmd_src), .pc_in(pc_in),
    .cmd_ready(cmd_ready), .done(done), .pop_data(pop_data), .pc_wr(pc_wr),
    .pc_out(pc_out), .sr_wr(sr_wr), .sr_out(sr_out), .sp_out(sp_out),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  logic [15:0] mem [0:127];
  logic [15:0] ref_mem [0:127];
  assign mem_rdata = mem[mem_addr[7:1]];

  int total = 0;
  int bad = 0;
  int sr_seen = 0;
  int req_seen = 0;
  int acc_n = 0;
  logic [15:0] sr_got;
  logic [15:0] acc_addr [0:3];
  logic        acc_we [0:3];
  logic [15:0] acc_wd [0:3];
  logic        fast_ack = 1'b1;
  logic        wait_prev = 1'b0;
  logic [15:0] prev_addr, prev_wd;
  logic [15:0] exp_sp;

  function automatic logic [15:0] sized(logic [15:0] v, logic b);
    return b ? (v & 16'h00FF) : v;
  endfunction

  function automatic int slot(logic [15:0] a);
    return int'(a[7:1]);
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model and handshake monitor
  always @(negedge clk) begin
    if (sr_wr) begin sr_seen++; sr_got = sr_out; end
    if (rst_n && mem_req) begin
      req_seen++;
      if (wait_prev) chk(mem_addr == prev_addr && mem_wdata == prev_wd, "R9 hold", mem_addr, prev_addr);
      if (fast_ack || ($urandom % 3 == 0)) begin
        mem_ack = 1'b1;
        wait_prev = 1'b0;
        if (acc_n < 4) begin
          acc_addr[acc_n] = mem_addr; acc_we[acc_n] = mem_we; acc_wd[acc_n] = mem_wdata;
        end
        acc_n++;
        if (mem_we) mem[mem_addr[7:1]] = mem_wdata;
      end else begin
        mem_ack = 1'b0;
        wait_prev = 1'b1;
        prev_addr = mem_addr; prev_wd = mem_wdata;
      end
    end else begin
      mem_ack = 1'b0;
      wait_prev = 1'b0;
    end
  end

  task automatic run_cmd(input logic [2:0] op, input logic b, input logic [15:0] src,
                         input logic [15:0] pc, input logic noise);
    logic [15:0] sp0, e_addr0, e_addr1, e_wd, e_pc, e_pop, e_sr;
    int e_n;
    logic e_we, e_pcwr;
    string tg;
    sp0 = exp_sp; e_n = 1; e_we = 1'b0; e_pcwr = 1'b0; e_wd = '0;
    e_addr0 = sp0; e_addr1 = '0; e_pc = '0; e_pop = '0; e_sr = '0;
    case (op)
      3'd0: begin
        tg = b ? "R3" : "R2";
        e_we = 1'b1; e_addr0 = sp0 - 16'd2; e_wd = sized(src, b);
        ref_mem[slot(e_addr0)] = e_wd; exp_sp = sp0 - 16'd2;
      end
      3'd1: begin
        tg = b ? "R5" : "R4";
        e_pop = sized(ref_mem[slot(sp0)], b); exp_sp = sp0 + 16'd2;
      end
      3'd2: begin
        tg = "R6";
        e_we = 1'b1; e_addr0 = sp0 - 16'd2; e_wd = pc + 16'd2; e_pcwr = 1'b1; e_pc = src;
        ref_mem[slot(e_addr0)] = e_wd; exp_sp = sp0 - 16'd2;
      end
      3'd3: begin
        tg = "R7";
        e_pcwr = 1'b1; e_pc = ref_mem[slot(sp0)]; exp_sp = sp0 + 16'd2;
      end
      default: begin
        tg = "R8";
        e_n = 2; e_addr1 = sp0 + 16'd2; e_pcwr = 1'b1;
        e_sr = ref_mem[slot(sp0)]; e_pc = ref_mem[slot(e_addr1)]; exp_sp = sp0 + 16'd4;
      end
    endcase
    @(negedge clk);
    acc_n = 0; sr_seen = 0;
    cmd_valid = 1'b1; cmd_op = op; cmd_byte = b; cmd_src = src; pc_in = pc;
    @(negedge clk);
    cmd_valid = noise; cmd_op = 3'd1; cmd_src = ~src;
    while (done !== 1'b1) @(negedge clk);
    cmd_valid = 1'b0;
    chk(sp_out == exp_sp, {tg, " sp"}, sp_out, exp_sp);
    chk(pc_wr == e_pcwr, {tg, " pc_wr"}, {15'd0, pc_wr}, {15'd0, e_pcwr});
    if (e_pcwr) chk(pc_out == e_pc, {tg, " pc_out"}, pc_out, e_pc);
    if (op == 3'd1) chk(pop_data == e_pop, {tg, " pop_data"}, pop_data, e_pop);
    chk(acc_n == e_n, {tg, " access count"}, 16'(acc_n), 16'(e_n));
    chk(acc_addr[0] == e_addr0 && acc_we[0] == e_we, {tg, " first access"}, acc_addr[0], e_addr0);
    if (e_we) chk(acc_wd[0] == e_wd, {tg, " write data"}, acc_wd[0], e_wd);
    if (op == 3'd4) begin
      chk(acc_addr[1] == e_addr1 && !acc_we[1], "R8 second read", acc_addr[1], e_addr1);
      chk(sr_seen == 1 && sr_got == e_sr, "R8 status restore", sr_got, e_sr);
    end else begin
      chk(sr_seen == 0, {tg, " no sr_wr"}, 16'(sr_seen), 16'd0);
    end
    @(negedge clk);
    chk(!done && cmd_ready && !mem_req, "R10 single done", {13'd0, done, cmd_ready, mem_req}, 16'h0002);
    chk(sp_out == exp_sp, "R10 sp after", sp_out, exp_sp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd41));
    for (int i = 0; i < 128; i++) begin
      mem[i] = 16'(i * 16'h0313) ^ 16'h5A3C;
      ref_mem[i] = 16'(i * 16'h0313) ^ 16'h5A3C;
    end
    repeat (3) @(negedge clk);
    chk(sp_out == TOP_EXP, "R1 reset sp", sp_out, TOP_EXP);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sp_out == TOP_EXP && cmd_ready && !done && !mem_req, "R1 reset state", sp_out, TOP_EXP);
    exp_sp = TOP_EXP;

    // directed corners
    run_cmd(3'd0, 1'b0, 16'h1234, 16'h0000, 1'b0);   // R2
    run_cmd(3'd0, 1'b1, 16'hABCD, 16'h0000, 1'b0);   // R3
    chk(mem[slot(exp_sp)] == 16'h00CD, "R3 stored zero-extended", mem[slot(exp_sp)], 16'h00CD);
    mem[slot(exp_sp)] = 16'hBEEF; ref_mem[slot(exp_sp)] = 16'hBEEF;
    run_cmd(3'd1, 1'b1, 16'h0000, 16'h0000, 1'b0);   // R5 low byte only
    run_cmd(3'd1, 1'b0, 16'h0000, 16'h0000, 1'b1);   // R4, R10 noise
    fast_ack = 1'b0;
    run_cmd(3'd2, 1'b0, 16'h8000, 16'h0FFE, 1'b1);   // R6 slow acks, R9
    run_cmd(3'd3, 1'b0, 16'h0000, 16'h0000, 1'b0);   // R7
    chk(pc_out == 16'h1000, "R7 return address", pc_out, 16'h1000);
    run_cmd(3'd0, 1'b0, 16'h4444, 16'h0000, 1'b0);   // saved PC
    run_cmd(3'd0, 1'b0, 16'h0107, 16'h0000, 1'b0);   // saved SR
    run_cmd(3'd4, 1'b0, 16'h0000, 16'h0000, 1'b1);   // R8
    chk(sr_out == 16'h0107 && pc_out == 16'h4444, "R8 order", pc_out, 16'h4444);

    // R11 unknown codes
    for (int c = 5; c < 8; c++) begin
      @(negedge clk);
      req_seen = 0;
      cmd_valid = 1'b1; cmd_op = 3'(c); cmd_src = 16'hFFFF;
      repeat (3) @(negedge clk);
      cmd_valid = 1'b0;
      chk(req_seen == 0 && cmd_ready && !done, "R11 ignored op", 16'(req_seen), 16'd0);
      chk(sp_out == exp_sp, "R11 sp unchanged", sp_out, exp_sp);
    end

    // random mix
    for (int k = 0; k < 300; k++) begin
      fast_ack = 1'($urandom % 2);
      run_cmd(3'($urandom % 5), 1'($urandom % 2), 16'($urandom),
              16'($urandom) & 16'hFFFE, 1'($urandom % 2));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule